// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets any core post software interrupts to any group of cores. Each core owns a 16-bit pending-cause register. Sixteen set locations, one per cause bit, take a target-core mask: writing it posts that cause bit to every core named in the mask. Each core's cause register can be read back, and writing ones to it clears those bits.

The sixteen cause bits form four fixed groups: bit 0, bits 3:1, bits 7:4 and bits 15:8. A single shared 8-bit steering register holds a 2-bit line number for each group. For every core the block drives a 3-bit interrupt vector: each group that has any pending bit raises the line its field selects. The group contributions are ORed, and a group steered to line 3 raises nothing. The register port takes one word access per cycle. Read data appears one cycle after the request.

Top module: `ipi_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every cause register, the steering register, every core's interrupt vector and the read data are zero.
- R2: A write of value v to word index 0x140+k (k = 0..15) sets cause bit k of every core c with v[c] = 1. Other cores, other cause bits, and mask bits at or above the core count are left as they were.
- R3: A write of value v to word index 0x100+c clears those bits of core c's cause register that are 1 in v[15:0]. Its other bits and all other cores are unchanged.
- R4: A read of word index 0x100+c returns core c's cause register in bits 15:0, with zeros above, on bus_rdata in the cycle after the request.
- R5: A read of any set location (0x140 to 0x14f) returns zero.
- R6: Word index 0x190 is the steering register. A write stores wdata[7:0]. A read returns it zero-extended.
- R7: Per core, cause bit 0 raises line steer[1:0], any bit of cause[3:1] raises line steer[3:2], any bit of cause[7:4] raises line steer[5:4], and any bit of cause[15:8] raises line steer[7:6]. The raised lines are ORed. Core c's vector is core_irq[3c+2:3c], with line n at bit n.
- R8: A group whose steering field is 3 contributes no line.
- R9: Writes to unmapped word indices, including cause indices at or above the core count and 0x191, change no state. Reads of them return zero, as does bus_rdata in any cycle after a non-read.
- R10: core_irq reflects a write from the clock edge that accepts it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| core_irq | output | 3*NUM_CORES | Interrupt vector, 3 lines per core |

## Verification
The bench reprograms the steering register while causes are pending and expects every core's vector to re-map at once. It steers groups to line 3 to check that they vanish. A design that kept the value or wrapped it into line 0 would show a stray bit. It posts with mask bits above the core count and writes a cause index just past the last core; a loose address or mask decode would then corrupt a neighbouring core. Write-one-to-clear is checked with partial masks, so a design that cleared the whole register or inverted the mask would read back the wrong value.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CAUSE_W = 16;
    localparam int LINE_W  = 3;
    localparam int PART_W  = 8;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int GROUPS  = 4;
    localparam int SEL_W   = 2;

    localparam logic [ADDR_W-1:0] CAUSE_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] SET_BASE   = 12'h140;
    localparam logic [ADDR_W-1:0] STEER_ADDR = 12'h190;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       cause_hit;
        logic       set_hit;
        logic       steer_hit;
        logic [3:0] idx;
    } dec_t;

    // Group activity folded onto the line numbers chosen by the steering fields.
    function automatic logic [LINE_W-1:0] steer_lines(input logic [CAUSE_W-1:0] cause,
                                                      input logic [PART_W-1:0]  steer);
        logic [GROUPS-1:0]       active;
        logic [(1<<SEL_W)-1:0]   wide;
        active[0] = cause[0];
        active[1] = |cause[3:1];
        active[2] = |cause[7:4];
        active[3] = |cause[15:8];
        wide = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (active[g]) wide[steer[SEL_W*g +: SEL_W]] = 1'b1;
        end
        return wide[LINE_W-1:0];
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec           = '0;
        dec.wr        = req && we;
        dec.rd        = req && !we;
        dec.idx       = addr[3:0];
        dec.cause_hit = req && (addr[ADDR_W-1:4] == CAUSE_BASE[ADDR_W-1:4])
                            && (int'(addr[3:0]) < NUM_CORES);
        dec.set_hit   = req && (addr[ADDR_W-1:4] == SET_BASE[ADDR_W-1:4]);
        dec.steer_hit = req && (addr == STEER_ADDR);
    end

endmodule

// File: rtl/ipi_core_slice.sv
module ipi_core_slice
    import ipi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [CAUSE_W-1:0] set_bits,
    input  logic               clr_en,
    input  logic [CAUSE_W-1:0] clr_bits,
    input  logic [PART_W-1:0]  steer,
    output logic [CAUSE_W-1:0] cause,
    output logic [LINE_W-1:0]  irq
);

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.cause = st_d.cause & ~clr_bits;
        if (set_en) st_d.cause = st_d.cause | set_bits;   // set wins over clear
        cause = st_q.cause;
        irq   = steer_lines(st_q.cause, steer);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((cause & $past(set_bits)) == $past(set_bits)));

    p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((cause & $past(clr_bits)) == '0));

    p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(cause));

    p_quiet_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause == '0) |-> (irq == '0));

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [LINE_W*NUM_CORES-1:0] core_irq
);

    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    typedef struct packed {
        logic [PART_W-1:0] steer;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t st_d, st_q;
    dec_t dec;

    logic [CAUSE_W-1:0] cause_all [NUM_CORES];
    logic [CAUSE_W-1:0] set_bits;

    ipi_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .dec  (dec)
    );

    assign set_bits = CAUSE_W'(1) << dec.idx;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic set_en_c;
        logic clr_en_c;
        assign set_en_c = dec.set_hit && dec.wr && bus_wdata[c];
        assign clr_en_c = dec.cause_hit && dec.wr && (dec.idx == 4'(c));

        ipi_core_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (set_en_c),
            .set_bits (set_bits),
            .clr_en   (clr_en_c),
            .clr_bits (bus_wdata[CAUSE_W-1:0]),
            .steer    (st_q.steer),
            .cause    (cause_all[c]),
            .irq      (core_irq[LINE_W*c +: LINE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (dec.steer_hit && dec.wr) st_d.steer = bus_wdata[PART_W-1:0];
        if (dec.rd) begin
            if (dec.cause_hit)
                st_d.rdata = {{(DATA_W-CAUSE_W){1'b0}}, cause_all[dec.idx[IDX_W-1:0]]};
            else if (dec.steer_hit)
                st_d.rdata = {{(DATA_W-PART_W){1'b0}}, st_q.steer};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    p_steer_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.steer_hit && dec.wr) |=> (st_q.steer == $past(bus_wdata[PART_W-1:0])));

    p_steer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.steer_hit && dec.wr) |=> $stable(st_q.steer));

    p_set_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.set_hit && dec.rd) |=> (bus_rdata == '0));

endmodule

// File: tb/ipi_unit_test.sv
module ipi_unit_test;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3*NC-1:0] core_irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    ipi_unit #(.NUM_CORES(NC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_irq  (core_irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [11:0] exp_irq;
        logic [3:0]  req;
    } vec_t;

    // Starting from reset (steering 0). Core c owns core_irq[3c+2:3c].
    localparam vec_t VECS [20] = '{
        '{1'b1, 12'h140, 32'h0000_0005, 32'h0,      12'h041, 4'd2},  // R2 cores 0,2 bit0
        '{1'b0, 12'h100, 32'h0,         32'h1,      12'h041, 4'd4},  // R4
        '{1'b0, 12'h101, 32'h0,         32'h0,      12'h041, 4'd4},  // R4
        '{1'b1, 12'h149, 32'hFFFF_FFF2, 32'h0,      12'h049, 4'd2},  // R2 high mask bits ignored
        '{1'b1, 12'h190, 32'h0000_00E4, 32'h0,      12'h041, 4'd8},  // R8 group3 -> line 3
        '{1'b0, 12'h190, 32'h0,         32'hE4,     12'h041, 4'd6},  // R6
        '{1'b1, 12'h143, 32'h0000_0002, 32'h0,      12'h051, 4'd7},  // R7 group1 -> line1
        '{1'b1, 12'h146, 32'h0000_0008, 32'h0,      12'h851, 4'd7},  // R7 group2 -> line2
        '{1'b1, 12'h190, 32'h0000_001B, 32'h0,      12'h428, 4'd7},  // R7 remap, R8 group0 lost
        '{1'b1, 12'h101, 32'h0000_0008, 32'h0,      12'h408, 4'd3},  // R3 partial clear
        '{1'b0, 12'h101, 32'h0,         32'h200,    12'h408, 4'd3},  // R3 remainder kept
        '{1'b1, 12'h104, 32'h0000_FFFF, 32'h0,      12'h408, 4'd9},  // R9 index past cores
        '{1'b1, 12'h191, 32'h0,         32'h0,      12'h408, 4'd9},  // R9 unmapped
        '{1'b0, 12'h190, 32'h0,         32'h1B,     12'h408, 4'd9},  // R9 steering intact
        '{1'b0, 12'h145, 32'h0,         32'h0,      12'h408, 4'd5},  // R5
        '{1'b0, 12'h104, 32'h0,         32'h0,      12'h408, 4'd9},  // R9 read zero
        '{1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0,      12'h408, 4'd3},  // R3 full clear
        '{1'b0, 12'h100, 32'h0,         32'h0,      12'h408, 4'd3},  // R3
        '{1'b1, 12'h14F, 32'h0000_000F, 32'h0,      12'h649, 4'd2},  // R2 all cores bit15
        '{1'b1, 12'h103, 32'h0000_8000, 32'h0,      12'h449, 4'd3}   // R3 core3
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic xfer(input logic we, input logic [11:0] a, input logic [31:0] d);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "irq in reset", 32'(core_irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "irq after reset", 32'(core_irq), 32'h0);
        check("R1", "rdata after reset", bus_rdata, 32'h0);
        xfer(1'b0, 12'h190, 32'h0);
        check("R1", "steering reset", bus_rdata, 32'h0);

        for (int i = 0; i < 20; i++) begin
            xfer(VECS[i].we, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d irq", i),
                  32'(core_irq), 32'(VECS[i].exp_irq));
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rdata", i),
                  bus_rdata, VECS[i].exp_rd);
        end

        // R2: an empty mask posts nothing
        xfer(1'b1, 12'h140, 32'h0);
        check("R2", "empty mask", 32'(core_irq), 32'h449);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        #1;
        check("R1", "irq under reset", 32'(core_irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(1'b0, 12'h190, 32'h0);
        check("R1", "steering cleared", bus_rdata, 32'h0);
        xfer(1'b0, 12'h101, 32'h0);
        check("R1", "cause cleared", bus_rdata, 32'h0);

        // R10: vector follows the accepting edge directly
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h141; bus_wdata = 32'h1;
        #1;
        check("R10", "before edge", 32'(core_irq), 32'h0);
        @(posedge clk);
        #1;
        check("R10", "after edge", 32'(core_irq), 32'h001);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule